// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Power-Off Request

This block is a real-time counter peripheral on a simple 32-bit register bus. A prescaler divides the system clock down to a single-cycle tick enable, nominally at 32768 ticks per second. Each tick advances a 47-bit counter. Software sees the counter through two registers. The low word holds bits 31:0. The high word holds bits 46:32 in its bits 14:0. Writing either word reloads only that part of the counter and keeps the live value of the other part.

A 32-bit control register is stored and read back unchanged. When one write to it sets both the power-off-enable bit (bit 5) and the turn-off-power bit (bit 6), the block pulses `poweroff_o` for one cycle. Software places the block in a 4 KB window. Only the three mapped words respond. Every other offset reads zero, and a write to it has no effect.

Top module: `lp_rtc_top`

## Requirements
- R1: The prescaler makes one tick every TICK_DIV clock cycles. The first tick after reset lands on the TICK_DIV-th rising edge. Each tick adds one to the counter, and the counter does not change between ticks.
- R2: A read of word offset 0x24 returns counter bits 46:32 in data bits 14:0. Data bits 31:15 read as zero.
- R3: A read of word offset 0x28 returns counter bits 31:0.
- R4: A write to 0x24 loads wdata bits 14:0 into counter bits 46:32 and leaves bits 31:0 unchanged. A tick in the same cycle is dropped.
- R5: A write to 0x28 loads wdata into counter bits 31:0 and leaves bits 46:32 unchanged. A tick in the same cycle is dropped.
- R6: The control register at 0x38 is zero after reset and reads back exactly the last value written to it.
- R7: `poweroff_o` is high for exactly the cycle after a control write that has both bit 5 and bit 6 set. A control write with only one of these bits set, or neither, gives no pulse.
- R8: Decoding uses address bits 11:2. A read of any other word returns zero, and a write to any other word changes no register.
- R9: The counter wraps from all ones (high 0x7FFF, low 0xFFFFFFFF) to zero on the next tick.
- R10: Asserting `rst_ni` low clears the counter, the control register and the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address in the 4 KB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| poweroff_o | output | 1 | One-cycle power-off request |

## Verification
The hardest case to reach is a counter write that lands exactly on a tick edge, where the tick must be dropped. A write must also keep the other half of the counter while it is still counting. The bench tracks the prescaler phase arithmetically. It waits until its model says the next edge carries a tick, then issues the write there. The wrap case needs the counter at its maximum value, so the bench loads all ones through both words and lets ticks run across the boundary. A full sweep of all 1024 word offsets, for reads and for stray writes, covers the unmapped decode.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam int unsigned CNT_W   = 47;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LO_W    = 32;
  localparam int unsigned HI_W    = CNT_W - LO_W;
  localparam int unsigned WORD_W  = 10;
  localparam logic [WORD_W-1:0] WRD_HI   = 10'h009; // byte 0x24
  localparam logic [WORD_W-1:0] WRD_LO   = 10'h00A; // byte 0x28
  localparam logic [WORD_W-1:0] WRD_CTRL = 10'h00E; // byte 0x38
  localparam int unsigned PWR_EN_BIT  = 5;
  localparam int unsigned PWR_OFF_BIT = 6;
endpackage

// File: rtl/lp_rtc_prescaler.sv
module lp_rtc_prescaler #(
  parameter int unsigned TICK_DIV = 6104
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick_o = (phase_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (tick_o) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

  p_phase_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= LAST);

  generate
    if (TICK_DIV > 1) begin : g_multi
      p_tick_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/lp_rtc_counter.sv
module lp_rtc_counter
  import lp_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Writes win over a coincident tick.
  always_comb begin
    cnt_d = cnt_q;
    if (wr_hi_i)      cnt_d = {wdata_i[HI_W-1:0], cnt_q[LO_W-1:0]};
    else if (wr_lo_i) cnt_d = {cnt_q[CNT_W-1:LO_W], wdata_i[LO_W-1:0]};
    else if (tick_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_inc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_hi_i && !wr_lo_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_hi_i && !wr_lo_i) |=> $stable(cnt_q));
  p_hi_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (cnt_q[LO_W-1:0] == $past(cnt_q[LO_W-1:0]))
             && (cnt_q[CNT_W-1:LO_W] == $past(wdata_i[HI_W-1:0])));
  p_lo_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (cnt_q[CNT_W-1:LO_W] == $past(cnt_q[CNT_W-1:LO_W]))
             && (cnt_q[LO_W-1:0] == $past(wdata_i)));
  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_hi_i && !wr_lo_i && (&cnt_q)) |=> (cnt_q == '0));
  p_wr_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_hi_i && wr_lo_i));
endmodule

// File: rtl/lp_rtc_regs.sv
module lp_rtc_regs
  import lp_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wr_hi_o,
  output logic              wr_lo_o,
  output logic              poweroff_o
);
  logic [WORD_W-1:0] word;
  logic              sel_hi, sel_lo, sel_ctrl, wr_ctrl, off_req;
  logic [DATA_W-1:0] ctrl_q;
  logic              pwr_q;

  assign word     = addr_i[WORD_W+1:2];
  assign sel_hi   = (word == WRD_HI);
  assign sel_lo   = (word == WRD_LO);
  assign sel_ctrl = (word == WRD_CTRL);

  assign wr_hi_o  = req_i && we_i && sel_hi;
  assign wr_lo_o  = req_i && we_i && sel_lo;
  assign wr_ctrl  = req_i && we_i && sel_ctrl;
  assign off_req  = wr_ctrl && wdata_i[PWR_EN_BIT] && wdata_i[PWR_OFF_BIT];

  always_comb begin
    rdata_o = '0;
    if (sel_hi)        rdata_o[HI_W-1:0] = cnt_i[CNT_W-1:LO_W];
    else if (sel_lo)   rdata_o           = cnt_i[LO_W-1:0];
    else if (sel_ctrl) rdata_o           = ctrl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pwr_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      pwr_q <= off_req;
    end
  end

  assign poweroff_o = pwr_q;

  p_ctrl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(ctrl_q));
  p_ctrl_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (ctrl_q == $past(wdata_i)));
  p_pwr_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poweroff_o |-> $past(req_i && we_i && sel_ctrl
                         && wdata_i[PWR_EN_BIT] && wdata_i[PWR_OFF_BIT]));
  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_hi && !sel_lo && !sel_ctrl) |-> (rdata_o == '0));
  p_hi_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_hi |-> (rdata_o[DATA_W-1:HI_W] == '0));
endmodule

// File: rtl/lp_rtc_top.sv
module lp_rtc_top
  import lp_rtc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 6104,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              poweroff_o
);
  logic             tick, wr_hi, wr_lo;
  logic [CNT_W-1:0] cnt;

  lp_rtc_prescaler #(.TICK_DIV(TICK_DIV)) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  lp_rtc_counter i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .wr_hi_i(wr_hi),
    .wr_lo_i(wr_lo),
    .wdata_i(wdata_i),
    .cnt_o  (cnt)
  );

  lp_rtc_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt),
    .rdata_o   (rdata_o),
    .wr_hi_o   (wr_hi),
    .wr_lo_o   (wr_lo),
    .poweroff_o(poweroff_o)
  );
endmodule

// File: tb/test_lp_rtc_top.sv
module test_lp_rtc_top;
  localparam int DIV = 4;
  localparam logic [11:0] A_HI = 12'h024, A_LO = 12'h028, A_CT = 12'h038;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        poweroff_o;

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  // bench model
  int          m_phase = 0;
  logic [46:0] m_cnt   = '0;
  logic [31:0] m_ctrl  = '0;
  logic        m_pwr   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  lp_rtc_top #(.TICK_DIV(DIV)) i_lp_rtc_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .poweroff_o(poweroff_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a[11:2])
      10'h009: return {17'b0, m_cnt[46:32]};
      10'h00A: return m_cnt[31:0];
      10'h00E: return m_ctrl;
      default: return 32'h0;
    endcase
  endfunction

  // one clock: update model from inputs seen at the edge, then check pulse
  task automatic cyc();
    bit tk;
    @(posedge clk_i);
    tk = (m_phase == DIV - 1);
    m_phase = tk ? 0 : m_phase + 1;
    m_pwr = 1'b0;
    if (req_i && we_i && addr_i[11:2] == 10'h009)
      m_cnt = {wdata_i[14:0], m_cnt[31:0]};
    else if (req_i && we_i && addr_i[11:2] == 10'h00A)
      m_cnt = {m_cnt[46:32], wdata_i};
    else if (tk)
      m_cnt = m_cnt + 47'd1;
    if (req_i && we_i && addr_i[11:2] == 10'h00E) begin
      m_ctrl = wdata_i;
      m_pwr  = wdata_i[5] & wdata_i[6];
    end
    #1;
    chk("R7 poweroff", {31'b0, poweroff_o}, {31'b0, m_pwr});
  endtask

  task automatic idle();
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    cyc();
    idle();
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #0.5;
    chk(tag, rdata_o, exp_rd(a));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R10 reset state
    rd("R10 hi after reset", A_HI);
    rd("R10 lo after reset", A_LO);
    rd("R6 ctrl reset zero", A_CT);

    // R1: free counting, checked every cycle
    for (int i = 0; i < 5 * DIV + 3; i++) begin
      cyc();
      rd("R1 count lo", A_LO);
      rd("R2 count hi", A_HI);
    end

    // R8: full read sweep over every word
    for (int w = 0; w < 1024; w++) begin
      rd("R8 read sweep", 12'(w * 4));
      cyc();
    end

    // R2/R3/R4/R5 loads with several patterns
    for (int p = 0; p < 6; p++) begin
      logic [31:0] d;
      d = 32'hA5A5_0000 ^ (32'h1357_9BDF * p) ^ {p[15:0], 16'h0};
      wr(A_HI, d);
      rd("R4 hi write", A_HI);
      rd("R4 lo kept", A_LO);
      wr(A_LO, ~d);
      rd("R5 lo write", A_LO);
      rd("R5 hi kept", A_HI);
      cyc();
    end
    wr(A_HI, 32'hFFFF_FFFF);
    rd("R2 hi upper bits zero", A_HI);

    // R4/R5: writes landing on a tick edge drop the tick
    for (int k = 0; k < 2; k++) begin
      while (m_phase != DIV - 1) cyc();
      wr(k == 0 ? A_LO : A_HI, 32'h0000_1230 + 32'(k));
      rd(k == 0 ? "R5 tick lost" : "R4 tick lost", A_LO);
      rd(k == 0 ? "R5 tick lost hi" : "R4 tick lost hi", A_HI);
    end

    // R9 wrap
    wr(A_HI, 32'h0000_7FFF);
    wr(A_LO, 32'hFFFF_FFFF);
    rd("R9 preload", A_LO);
    for (int i = 0; i < 2 * DIV; i++) begin
      cyc();
      rd("R9 wrap lo", A_LO);
      rd("R9 wrap hi", A_HI);
    end
    chk("R9 wrapped past zero", {31'b0, m_cnt < 47'd3}, 32'd1);

    // R6/R7: all four combinations of the two bits, with other bits
    for (int c = 0; c < 16; c++) begin
      logic [31:0] d;
      d = (32'hC3C3_1E0F * (c + 1)) & ~32'h60;
      d[5] = c[0]; d[6] = c[1];
      if (c[2]) begin
        wr(A_CT, d);
      end else begin
        req_i = 1'b1; we_i = 1'b1; addr_i = A_CT; wdata_i = d;
        cyc();
        wdata_i = d ^ 32'h0000_0060;
        cyc();
        idle();
      end
      rd("R6 ctrl readback", A_CT);
      cyc();
      rd("R6 ctrl held", A_CT);
    end

    // R8: stray writes to every unmapped word change nothing
    for (int w = 0; w < 1024; w++) begin
      if (w != 9 && w != 10 && w != 14) begin
        wr(12'(w * 4) | 12'(w % 4), 32'hDEAD_BEEF ^ 32'(w));
        rd("R8 unmapped write ctrl", A_CT);
      end
    end
    rd("R8 unmapped write lo", A_LO);
    rd("R8 unmapped write hi", A_HI);

    // R10: reset mid-run clears counter, control and prescaler phase
    wr(A_CT, 32'h1234_5678);
    wr(A_LO, 32'h0000_0500);
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    m_cnt = '0; m_ctrl = '0; m_phase = 0; m_pwr = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    rd("R10 lo cleared", A_LO);
    rd("R10 ctrl cleared", A_CT);
    for (int i = 0; i < DIV; i++) begin
      cyc();
      rd("R10 first tick timing", A_LO);
    end
    idle();
    cyc();

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule